// File: doc/BRIEF.md
# Write Enable Latch for a Serial-Bus Register Slave

This block stands between the front end of a serial-bus slave and the storage behind it (volatile registers and nonvolatile array alike). It holds one volatile enable bit that gates every write. While the bit is clear, a data byte aimed at any location other than the latch's own control register is dropped: the storage never sees a write permit, and the slave returns no acknowledge for that byte.

The enable bit is controlled only through its own register at address 86h. The byte 80h sets it and the byte 00h clears it. Any other byte written there is acknowledged and changes nothing. Writes to this register never reach the storage. The register reads back with the enable bit in bit 7 and zeros in every other bit. After reset the bit is clear, and it holds its value until software writes it again or power is cycled.

The write-permit and acknowledge decisions are combinational from the strobe, the address and the current latch value, so the bus engine can use them in the same cycle. The latch itself takes its new value on the clock edge that ends the strobe cycle.

Top module: `write_enable_latch`

## Requirements
- R1: After reset the latch is clear and the read-back byte is 00h.
- R2: A strobed write of 80h to address 86h sets the latch; from the next cycle the read-back byte is 80h.
- R3: A strobed write of 00h to address 86h clears the latch; from the next cycle the read-back byte is 00h.
- R4: A strobed write to address 86h with any data other than 80h or 00h leaves the latch unchanged and is acknowledged.
- R5: Every strobed write to address 86h gets `ack` high in its strobe cycle, and `wr_permit` stays low for it.
- R6: While the latch is clear, a strobed write to any address other than 86h gets `wr_permit` low and `ack` low.
- R7: While the latch is set, a strobed write to any address other than 86h gets `wr_permit` high and `ack` high, and the latch stays set.
- R8: The read-back byte has the latch value in bit 7, and bits 6 to 0 are always 0.
- R9: With `wr_stb` low, `wr_permit` and `ack` are low and the latch holds its value, whatever the address and data inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears the latch |
| wr_stb | input | 1 | Decoded data-byte write strobe, one cycle per byte |
| wr_addr | input | 8 | Target address of the byte being written |
| wr_data | input | 8 | Data byte being written |
| wr_permit | output | 1 | Allows the register file or memory to take the byte |
| ack | output | 1 | High to acknowledge the data byte, low to withhold it |
| rd_data | output | 8 | Read-back value of the latch's control register |

## Verification
`wr_permit` and `ack` are due in the same cycle as the strobe, so the bench drives inputs on the falling edge and samples these two outputs shortly after, before the next rising edge. The latch and `rd_data` change on the rising edge that ends the strobe cycle, so the read-back is sampled just after that edge and compared with a reference bit that the bench updates at the same point. Each cycle of every sequence is checked this way against that behavioural model. The sequences include idle cycles with address 86h on the bus, off-code bytes to 86h in both latch states, and repeated sets and clears.

// File: rtl/wel_pkg.sv
package wel_pkg;

    typedef struct packed {
        logic en;
    } wel_state_t;

    typedef struct packed {
        logic hit;
        logic set_code;
        logic clr_code;
    } wel_match_t;

endpackage

// File: rtl/wel_decode.sv
module wel_decode #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] LATCH_ADDR = 8'h86,
    parameter logic [DATA_W-1:0] SET_CODE   = 8'h80,
    parameter logic [DATA_W-1:0] CLR_CODE   = 8'h00
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output wel_pkg::wel_match_t match
);
    always_comb begin
        match          = '0;
        match.hit      = (addr == LATCH_ADDR);
        match.set_code = (data == SET_CODE);
        match.clr_code = (data == CLR_CODE);
    end
endmodule

// File: rtl/wel_state.sv
module wel_state (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    input  wel_pkg::wel_match_t match,
    output logic en_q
);
    wel_pkg::wel_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (stb && match.hit) begin
            if (match.set_code)
                st_d.en = 1'b1;
            else if (match.clr_code)
                st_d.en = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign en_q = st_q.en;

    // R2: set code to the latch register sets it
    a_r2_set_latch: assert property (@(posedge clk) disable iff (!rst_n)
        stb && match.hit && match.set_code |=> en_q);

    // R3: clear code to the latch register clears it
    a_r3_clear_latch: assert property (@(posedge clk) disable iff (!rst_n)
        stb && match.hit && match.clr_code |=> !en_q);

    // R4: other codes leave it unchanged
    a_r4_other_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
        stb && match.hit && !match.set_code && !match.clr_code |=> $stable(en_q));

    // R7: writes elsewhere never move the latch
    a_r7_other_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        stb && !match.hit |=> $stable(en_q));

    // R9: no strobe, no change
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !stb |=> $stable(en_q));
endmodule

// File: rtl/wel_gate.sv
module wel_gate #(
    parameter int DATA_W = 8,
    parameter int EN_BIT = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    input  wel_pkg::wel_match_t match,
    input  logic en,
    output logic permit,
    output logic ack,
    output logic [DATA_W-1:0] rd_data
);
    always_comb begin
        permit = stb && !match.hit && en;
        ack    = stb && (match.hit || en);
    end

    for (genvar i = 0; i < DATA_W; i++) begin : g_rd
        if (i == EN_BIT) begin : g_en
            assign rd_data[i] = en;
        end else begin : g_zero
            assign rd_data[i] = 1'b0;
        end
    end

    // R5: latch register writes acknowledged, never forwarded
    a_r5_self_write: assert property (@(posedge clk) disable iff (!rst_n)
        stb && match.hit |-> ack && !permit);

    // R6: latch clear blocks and withholds ack elsewhere
    a_r6_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        stb && !match.hit && !en |-> !permit && !ack);

    // R9: nothing without a strobe
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !stb |-> !permit && !ack);

    // R8: at most the enable bit is ever set
    a_r8_readback_shape: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rd_data) <= 1);
endmodule

// File: rtl/write_enable_latch.sv
module write_enable_latch #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int EN_BIT = 7,
    parameter logic [ADDR_W-1:0] LATCH_ADDR = 8'h86,
    parameter logic [DATA_W-1:0] SET_CODE   = 8'h80,
    parameter logic [DATA_W-1:0] CLR_CODE   = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_permit,
    output logic              ack,
    output logic [DATA_W-1:0] rd_data
);
    wel_pkg::wel_match_t match;
    logic en_q;

    wel_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .LATCH_ADDR(LATCH_ADDR), .SET_CODE(SET_CODE), .CLR_CODE(CLR_CODE)
    ) u_decode (
        .addr (wr_addr),
        .data (wr_data),
        .match(match)
    );

    wel_state u_state (
        .clk  (clk),
        .rst_n(rst_n),
        .stb  (wr_stb),
        .match(match),
        .en_q (en_q)
    );

    wel_gate #(.DATA_W(DATA_W), .EN_BIT(EN_BIT)) u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .stb    (wr_stb),
        .match  (match),
        .en     (en_q),
        .permit (wr_permit),
        .ack    (ack),
        .rd_data(rd_data)
    );

    // R1: reset leaves the latch clear
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |-> rd_data == '0);
endmodule

// File: tb/test_write_enable_latch.sv
`timescale 1ns/1ps
module test_write_enable_latch;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       wr_permit, ack;
    logic [7:0] rd_data;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    bit ref_en = 0;

    always #2.5 clk = ~clk;

    write_enable_latch i_write_enable_latch (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_permit(wr_permit), .ack(ack), .rd_data(rd_data)
    );

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // One cycle: drive at falling edge, check same-cycle outputs, then
    // update the model at the rising edge and check read-back.
    task automatic cyc(string req, bit stb, logic [7:0] addr, logic [7:0] data);
        bit exp_permit, exp_ack;
        @(negedge clk);
        wr_stb = stb; wr_addr = addr; wr_data = data;
        #1;
        exp_permit = stb && (addr != 8'h86) && ref_en;
        exp_ack    = stb && ((addr == 8'h86) || ref_en);
        chk({req, " permit"}, {7'd0, wr_permit}, {7'd0, exp_permit});
        chk({req, " ack"},    {7'd0, ack},       {7'd0, exp_ack});
        @(posedge clk);
        if (stb && addr == 8'h86) begin
            if (data == 8'h80) ref_en = 1;
            else if (data == 8'h00) ref_en = 0;
        end
        #1;
        chk({req, " readback"}, rd_data, {ref_en, 7'd0});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #100000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset readback", rd_data, 8'h00);
        chk("R1 reset ack", {7'd0, ack}, 8'h00);
        @(negedge clk); rst_n = 1'b1;

        cyc("R6 blocked clear", 1, 8'h10, 8'hAA);
        cyc("R6 blocked clear", 1, 8'h90, 8'h80);
        cyc("R4 odd code while clear", 1, 8'h86, 8'h55);
        cyc("R4 odd code while clear", 1, 8'h86, 8'h01);
        cyc("R9 idle set code", 0, 8'h86, 8'h80);
        cyc("R2 set", 1, 8'h86, 8'h80);
        cyc("R8 readback shape", 0, 8'h00, 8'hFF);
        cyc("R7 permitted", 1, 8'h10, 8'h00);
        cyc("R7 permitted", 1, 8'hD0, 8'h80);
        cyc("R7 permitted", 1, 8'h87, 8'h00);
        cyc("R5 self write no permit", 1, 8'h86, 8'h80);
        cyc("R4 odd code while set", 1, 8'h86, 8'hC0);
        cyc("R4 odd code while set", 1, 8'h86, 8'h7F);
        cyc("R9 idle clear code", 0, 8'h86, 8'h00);
        cyc("R3 clear", 1, 8'h86, 8'h00);
        cyc("R6 blocked after clear", 1, 8'h00, 8'h00);
        cyc("R3 clear again", 1, 8'h86, 8'h00);
        cyc("R2 set again", 1, 8'h86, 8'h80);
        for (int i = 0; i < 16; i++)
            cyc("R7 sweep", 1, 8'(i * 17), 8'(i * 13));
        cyc("R3 final clear", 1, 8'h86, 8'h00);
        for (int i = 0; i < 16; i++)
            cyc("R6 sweep", (i % 3) != 0, 8'(i * 29 + 1), 8'h80);
        finish_run();
    end
endmodule